// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block turns the addressing fields of a decoded memory operand into the address that goes out to memory on a 16-bit segmented processor. Decode supplies the 2-bit mode field, the 3-bit register/memory field and the displacement bytes. The block combines them with the current base and index registers to form a 16-bit offset. It then picks a segment register, either by a default rule or by an override that the prefix decoder has already resolved. The physical address is the segment value shifted left by four bits plus the offset.

The block has one register stage. A request presented with `in_valid` high produces registered results one clock later, along with `out_valid`. When no request is presented, the output registers keep their values. A mode value that names a register operand raises a flag and produces no memory address, so downstream logic can send the operand to the register file.

Top module: `seg_addr_gen`

## Requirements
- R1: For a memory operand, `pa` equals (selected segment value × 16) + `ea`, truncated to 20 bits.
- R2: With `mod_sel`=0, `rm_sel` selects the offset with no displacement: 0=BX+SI, 1=BX+DI, 2=BP+SI, 3=BP+DI, 4=SI, 5=DI, 7=BX.
- R3: With `mod_sel`=0 and `rm_sel`=6, `ea` is `disp` taken as a direct 16-bit address, and no register is added.
- R4: With `mod_sel`=1, only `disp[7:0]` is used. It is sign-extended to 16 bits and added to the register sum, and `disp[15:8]` has no effect.
- R5: With `mod_sel`=2, the full 16-bit `disp` is added to the register sum. For codes 1 and 2, `rm_sel`=6 means BP plus displacement.
- R6: The offset sum wraps modulo 2^16.
- R7: With no override, `seg_used` is SS (code 2) when the mode uses BP as its base (`rm_sel` 2 or 3, or `rm_sel` 6 with `mod_sel` not 0). Otherwise it is DS (code 3).
- R8: When `ovr_en`=1, `seg_used` equals `ovr_sel`. The segment codes are 0=ES, 1=CS, 2=SS, 3=DS.
- R9: With `mod_sel`=3, `reg_operand`=1 and `ea`, `pa` and `seg_used` are all zero. For any memory mode, `reg_operand`=0.
- R10: The outputs change on the clock edge after an accepted request. `out_valid` follows `in_valid` by one cycle. While `in_valid` is low, `ea`, `pa`, `seg_used` and `reg_operand` hold their values. Reset clears every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present |
| mod_sel | input | 2 | Mode field |
| rm_sel | input | 3 | Register/memory field |
| disp | input | 16 | Displacement or direct address |
| reg_bx | input | 16 | BX value |
| reg_bp | input | 16 | BP value |
| reg_si | input | 16 | SI value |
| reg_di | input | 16 | DI value |
| seg_es | input | 16 | ES value |
| seg_cs | input | 16 | CS value |
| seg_ss | input | 16 | SS value |
| seg_ds | input | 16 | DS value |
| ovr_en | input | 1 | Segment override present |
| ovr_sel | input | 2 | Override segment code |
| out_valid | output | 1 | Registered result valid |
| ea | output | 16 | Effective address |
| seg_used | output | 2 | Segment code applied |
| pa | output | 20 | Physical address |
| reg_operand | output | 1 | Operand is a register |

## Verification
Every register/memory code is run in mode 0 with distinct values in BX, BP, SI and DI, so a wrong pairing of base and index shows up as a wrong offset. A displacement whose upper byte is nonzero and whose bit 7 is set tells sign extension apart from zero extension, and also shows whether the upper byte leaks into mode 1. Values near 0xFFFF in the registers and segments check that the offset wraps at 16 bits before the segment is added, as opposed to a single wide sum. BP-based requests, issued with and without an override, separate the default segment rule from the override path. A pause in requests, during which the inputs are changed, shows whether the outputs hold.

// File: rtl/seg_addr_gen.sv
module seg_addr_gen (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [1:0]  mod_sel,
  input  logic [2:0]  rm_sel,
  input  logic [15:0] disp,
  input  logic [15:0] reg_bx,
  input  logic [15:0] reg_bp,
  input  logic [15:0] reg_si,
  input  logic [15:0] reg_di,
  input  logic [15:0] seg_es,
  input  logic [15:0] seg_cs,
  input  logic [15:0] seg_ss,
  input  logic [15:0] seg_ds,
  input  logic        ovr_en,
  input  logic [1:0]  ovr_sel,
  output logic        out_valid,
  output logic [15:0] ea,
  output logic [1:0]  seg_used,
  output logic [19:0] pa,
  output logic        reg_operand
);

  logic [15:0] base_v, index_v, disp_v, ea_c, seg_val;
  logic [1:0]  seg_c;
  logic        is_mem, direct, bp_base;
  logic [19:0] pa_c;

  assign is_mem  = (mod_sel != 2'd3);
  assign direct  = (mod_sel == 2'd0) && (rm_sel == 3'd6);
  assign bp_base = (rm_sel == 3'd2) || (rm_sel == 3'd3) || ((rm_sel == 3'd6) && !direct);

  always_comb begin
    base_v  = 16'h0;
    index_v = 16'h0;
    case (rm_sel)
      3'd0: begin base_v = reg_bx; index_v = reg_si; end
      3'd1: begin base_v = reg_bx; index_v = reg_di; end
      3'd2: begin base_v = reg_bp; index_v = reg_si; end
      3'd3: begin base_v = reg_bp; index_v = reg_di; end
      3'd4: index_v = reg_si;
      3'd5: index_v = reg_di;
      3'd6: base_v = direct ? 16'h0 : reg_bp;
      default: base_v = reg_bx;
    endcase
  end

  always_comb begin
    case (mod_sel)
      2'd0:    disp_v = direct ? disp : 16'h0;
      2'd1:    disp_v = {{8{disp[7]}}, disp[7:0]};
      2'd2:    disp_v = disp;
      default: disp_v = 16'h0;
    endcase
  end

  assign ea_c  = base_v + index_v + disp_v;
  assign seg_c = ovr_en ? ovr_sel : (bp_base ? 2'd2 : 2'd3);

  always_comb begin
    case (seg_c)
      2'd0:    seg_val = seg_es;
      2'd1:    seg_val = seg_cs;
      2'd2:    seg_val = seg_ss;
      default: seg_val = seg_ds;
    endcase
  end

  assign pa_c = {seg_val, 4'h0} + {4'h0, ea_c};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      ea          <= 16'h0;
      seg_used    <= 2'd0;
      pa          <= 20'h0;
      reg_operand <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        ea          <= is_mem ? ea_c : 16'h0;
        seg_used    <= is_mem ? seg_c : 2'd0;
        pa          <= is_mem ? pa_c : 20'h0;
        reg_operand <= !is_mem;
      end
    end
  end

endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [1:0]  mod_sel,
  input logic [2:0]  rm_sel,
  input logic [15:0] seg_es,
  input logic [15:0] seg_cs,
  input logic [15:0] seg_ss,
  input logic [15:0] seg_ds,
  input logic        ovr_en,
  input logic [1:0]  ovr_sel,
  input logic        out_valid,
  input logic [15:0] ea,
  input logic [1:0]  seg_used,
  input logic [19:0] pa,
  input logic        reg_operand
);

  function automatic logic [15:0] pick(input logic [1:0] c, input logic [15:0] e,
                                       input logic [15:0] k, input logic [15:0] s,
                                       input logic [15:0] d);
    case (c)
      2'd0:    pick = e;
      2'd1:    pick = k;
      2'd2:    pick = s;
      default: pick = d;
    endcase
  endfunction

  assert_pa_sum_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mod_sel != 2'd3) |=>
      pa == ({pick(seg_used, $past(seg_es), $past(seg_cs), $past(seg_ss), $past(seg_ds)), 4'h0} + {4'h0, ea}));

  assert_bp_default_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !ovr_en && mod_sel != 2'd3 &&
     (rm_sel == 3'd2 || rm_sel == 3'd3 || (rm_sel == 3'd6 && mod_sel != 2'd0))) |=> seg_used == 2'd2);

  assert_override_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ovr_en && mod_sel != 2'd3) |=> seg_used == $past(ovr_sel));

  assert_reg_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mod_sel == 2'd3) |=> (reg_operand && pa == 20'h0 && ea == 16'h0));

  assert_valid_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(pa) && $stable(ea) && $stable(seg_used)));

endmodule

bind seg_addr_gen seg_addr_gen_chk u_chk (.*);

// File: tb/test_seg_addr_gen.sv
module test_seg_addr_gen;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [1:0] mod_sel = 2'd0, ovr_sel = 2'd0;
  logic [2:0] rm_sel = 3'd0;
  logic [15:0] disp = 16'h0, reg_bx = 16'h0, reg_bp = 16'h0, reg_si = 16'h0, reg_di = 16'h0;
  logic [15:0] seg_es = 16'h1000, seg_cs = 16'h0100, seg_ss = 16'h3000, seg_ds = 16'h0200;
  logic ovr_en = 1'b0;
  logic out_valid, reg_operand;
  logic [15:0] ea;
  logic [1:0] seg_used;
  logic [19:0] pa;

  typedef struct {
    logic [15:0] ea;
    logic [1:0]  seg;
    logic [19:0] pa;
    logic        regf;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  seg_addr_gen i_seg_addr_gen (.*);

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  function automatic exp_t model(string tag);
    exp_t r;
    logic [15:0] off, d, s;
    logic [1:0] sc;
    logic bpb;
    r.tag = tag;
    if (mod_sel == 2'd3) begin
      r.ea = 0; r.seg = 0; r.pa = 0; r.regf = 1;
      return r;
    end
    d = (mod_sel == 2'd1) ? {{8{disp[7]}}, disp[7:0]} : (mod_sel == 2'd2 ? disp : 16'h0);
    case (rm_sel)
      3'd0: off = reg_bx + reg_si;
      3'd1: off = reg_bx + reg_di;
      3'd2: off = reg_bp + reg_si;
      3'd3: off = reg_bp + reg_di;
      3'd4: off = reg_si;
      3'd5: off = reg_di;
      3'd6: off = (mod_sel == 2'd0) ? disp : reg_bp;
      default: off = reg_bx;
    endcase
    r.ea = off + d;
    bpb = (rm_sel == 3'd2 || rm_sel == 3'd3 || (rm_sel == 3'd6 && mod_sel != 2'd0));
    sc = ovr_en ? ovr_sel : (bpb ? 2'd2 : 2'd3);
    s = (sc == 0) ? seg_es : (sc == 1) ? seg_cs : (sc == 2) ? seg_ss : seg_ds;
    r.seg = sc;
    r.pa = {s, 4'h0} + {4'h0, r.ea};
    r.regf = 0;
    return r;
  endfunction

  task automatic drive(input logic [1:0] m, input logic [2:0] rm, input logic [15:0] d,
                       input logic oe, input logic [1:0] os, input string tag);
    @(negedge clk);
    mod_sel = m; rm_sel = rm; disp = d; ovr_en = oe; ovr_sel = os; in_valid = 1'b1;
    sb.push_back(model(tag));
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      exp_t e;
      checks++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL R10: out_valid with no pending request (actual 1, expected 0)");
      end else begin
        e = sb.pop_front();
        if (ea !== e.ea || seg_used !== e.seg || pa !== e.pa || reg_operand !== e.regf) begin
          fails++;
          $display("FAIL %s: ea=%h seg=%0d pa=%h reg=%b expected ea=%h seg=%0d pa=%h reg=%b",
                   e.tag, ea, seg_used, pa, reg_operand, e.ea, e.seg, e.pa, e.regf);
        end
      end
    end
  end

  initial begin
    #100us;
    fails++;
    $display("FAIL watchdog: run did not complete (actual timeout, expected completion)");
    finish_run();
  end

  initial begin
    logic [19:0] held_pa;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 0 || pa !== 0 || ea !== 0 || seg_used !== 0 || reg_operand !== 0) begin
      fails++;
      $display("FAIL R10: reset state pa=%h ea=%h v=%b expected all zero", pa, ea, out_valid);
    end
    rst_n = 1'b1;
    reg_bx = 16'h1000; reg_bp = 16'h0100; reg_si = 16'h2000; reg_di = 16'h0040;

    for (int k = 0; k < 8; k++) drive(2'd0, 3'(k), 16'h1010, 1'b0, 2'd0, (k == 6) ? "R3" : "R2");
    drive(2'd2, 3'd7, 16'h1234, 1'b0, 2'd0, "R5");
    drive(2'd2, 3'd0, 16'h1234, 1'b0, 2'd0, "R5");
    drive(2'd1, 3'd4, 16'hAB80, 1'b0, 2'd0, "R4");
    drive(2'd1, 3'd5, 16'h5512, 1'b0, 2'd0, "R4");
    drive(2'd1, 3'd2, 16'h0005, 1'b0, 2'd0, "R7");
    drive(2'd2, 3'd6, 16'h0010, 1'b0, 2'd0, "R7");
    drive(2'd1, 3'd3, 16'h00FF, 1'b0, 2'd0, "R7");
    drive(2'd2, 3'd6, 16'h0010, 1'b1, 2'd0, "R8");
    drive(2'd0, 3'd4, 16'h0000, 1'b1, 2'd1, "R8");
    drive(2'd1, 3'd2, 16'h0001, 1'b1, 2'd3, "R8");
    drive(2'd3, 3'd5, 16'h1234, 1'b0, 2'd0, "R9");
    @(negedge clk);
    reg_bx = 16'hFFFF; reg_si = 16'h0002; seg_ds = 16'hFFFF; in_valid = 1'b0;
    drive(2'd2, 3'd0, 16'h0001, 1'b0, 2'd0, "R6");
    drive(2'd0, 3'd6, 16'hFFF0, 1'b0, 2'd0, "R1");
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    held_pa = pa;
    mod_sel = 2'd2; rm_sel = 3'd1; disp = 16'h4444; reg_di = 16'h7777;
    repeat (3) @(negedge clk);
    checks++;
    if (pa !== held_pa || out_valid !== 1'b0 || sb.size() != 0) begin
      fails++;
      $display("FAIL R10: hold pa=%h v=%b expected pa=%h v=0", pa, out_valid, held_pa);
    end
    finish_run();
  end
endmodule